// File: doc/BRIEF.md
# Converter Host Bus Interface and Mode Register

This block is the processor-facing side of a four-input, 12-bit analog-to-digital converter controller. It watches active-low chip-select, read and write strobes together with a register-select line, a high-byte-enable line and two channel-address lines. An access takes effect on the cycle in which its strobes go inactive, so a write is committed on its trailing edge. A write to the mode register changes the operating mode and also starts a conversion. A write to the data space latches the channel number.

The block sends one-cycle start-conversion and start-calibration pulses and steady mode levels to a separate sequencer. It takes back a result word with a valid strobe, a calibration-finished strobe with an overflow flag, and a supply-failure event. The 12-bit result is read as two bytes over an 8-bit bus. Inside a chip that bus appears as separate in, out and output-enable signals; the enable is meant to drive a three-state pad.

The mode register read-back layout is as follows. Bit 0 is latched-output mode. Bit 1 is calibration busy. Bit 2 is sample/hold control. Bit 3 is power-down. Bit 5 is the power-fail flag. Bit 7 is the calibration-error flag. Bits 4 and 6 read as zero.

Top module: `adc_host_if`

## Requirements
- R1: A mode register write is an access with reg_sel=1, hbe=1, cs_n=0, wr_n=0 and rd_n=1. It is committed on the first clock edge at which the strobes are no longer all active. After that edge the written bits 0, 2 and 3 read back in the same positions.
- R2: With bit 0 clear, every result_valid loads the output holding register. With bit 0 set, the first result after a release is held and later results are dropped. The release is a completed read of the high byte.
- R3: Writing bit 1 high gives one start_cal pulse, one cycle long. Read-back bit 1 is then 1 until cal_done.
- R4: Outputs latched_mode, sh_mode and pwr_down follow written bits 0, 2 and 3 respectively.
- R5: A mode write with bit 5 low clears the power-fail flag (read-back bit 5). A mode write with bit 5 high leaves the flag unchanged.
- R6: Every accepted mode register write gives exactly one start_conv pulse, one cycle long.
- R7: cal_done with cal_ovf=1 sets the calibration-error flag (read-back bit 7). A start_cal clears it. A cal_done with cal_ovf=0 leaves it clear.
- R8: The block ignores reserved writes. These are mode writes with data bit 4 or bit 6 high, and writes with reg_sel=1 and hbe=0. A reserved write changes no register bit and gives no pulse.
- R9: A write with reg_sel=0 latches addr into chan. It pulses start_conv only while sample/hold mode (bit 2) is off.
- R10: A read returns three kinds of data. reg_sel=1 with hbe=1 returns the mode register. reg_sel=0 with hbe=0 returns result bits 7:0. reg_sel=0 with hbe=1 returns result bits 11:8 in bits 3:0, with zeros above.
- R11: dq_oe is 1 exactly when cs_n=0 and rd_n=0.
- R12: A pwr_fail_evt clears bits 0, 1 and 2, sets bit 3 and sets the power-fail flag. It takes priority over a write committed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hbe | input | 1 | High-byte enable |
| reg_sel | input | 1 | 1 selects the mode register, 0 the data space |
| addr | input | 2 | Channel address |
| dq_i | input | 8 | Bus data in |
| dq_o | output | 8 | Bus data out |
| dq_oe | output | 1 | Bus output enable |
| result_valid | input | 1 | New conversion result strobe |
| result | input | 12 | Conversion result, straight binary |
| cal_done | input | 1 | Calibration finished strobe |
| cal_ovf | input | 1 | Calibration overflowed (with cal_done) |
| pwr_fail_evt | input | 1 | Supply failure event |
| start_conv | output | 1 | Start-conversion pulse |
| start_cal | output | 1 | Start-calibration pulse |
| latched_mode | output | 1 | Latched output mode level |
| sh_mode | output | 1 | Sample/hold control mode level |
| pwr_down | output | 1 | Power-down mode level |
| chan | output | 2 | Latched channel number |

## Verification
The bench first fills the mode register with set bits. It then sends reserved writes and checks that the read-back and the pulse counts are unchanged. A design that decodes too loosely would wipe the mode or start a spurious conversion.

In latched mode it feeds two results before any read. A design that overwrites the holding register would return the second result instead of the first.

It runs one calibration that overflows and a second that is clean. A wrong flag rule would leave the error set, or drop it too early.

It raises a supply failure while several modes are active. It checks the forced power-down state and that bit 5 clears only when written low. It also checks that a data-space write in sample/hold mode moves the channel without starting a conversion.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int RES_W = 12;
  localparam int BUS_W = 8;
  localparam int CH_W  = 2;

  // mode register bit positions (software visible, kept fixed)
  localparam int B_LATCH = 0;
  localparam int B_CAL   = 1;
  localparam int B_SH    = 2;
  localparam int B_PD    = 3;
  localparam int B_RSV0  = 4;
  localparam int B_PF    = 5;
  localparam int B_RSV1  = 6;
  localparam int B_CERR  = 7;

  typedef struct packed {
    logic pd;
    logic sh;
    logic latched;
  } mode_t;
endpackage

// File: rtl/adc_bus_strobe.sv
module adc_bus_strobe #(
  parameter int BUS_W = 8,
  parameter int CH_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             hbe,
  input  logic             reg_sel,
  input  logic [CH_W-1:0]  addr,
  input  logic [BUS_W-1:0] dq_i,
  output logic             wr_commit,
  output logic             rd_commit,
  output logic             c_hbe,
  output logic             c_rsel,
  output logic [CH_W-1:0]  c_addr,
  output logic [BUS_W-1:0] c_data
);
  logic wr_act, rd_act;
  logic wr_act_q, rd_act_q;

  assign wr_act = ~cs_n & ~wr_n & rd_n;
  assign rd_act = ~cs_n & ~rd_n & wr_n;

  // capture the fields on every active cycle; the last one wins
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      c_hbe    <= 1'b0;
      c_rsel   <= 1'b0;
      c_addr   <= '0;
      c_data   <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (wr_act || rd_act) begin
        c_hbe  <= hbe;
        c_rsel <= reg_sel;
        c_addr <= addr;
        c_data <= dq_i;
      end
    end
  end

  // trailing edge of the access
  assign wr_commit = wr_act_q & ~wr_act;
  assign rd_commit = rd_act_q & ~rd_act;

  p_commit_single_r1: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit);
endmodule

// File: rtl/adc_mode_reg.sv
module adc_mode_reg
  import adc_host_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_commit,
  input  logic             c_rsel,
  input  logic             c_hbe,
  input  logic [BUS_W-1:0] c_data,
  input  logic             cal_done,
  input  logic             cal_ovf,
  input  logic             pf_evt,
  output mode_t            mode,
  output logic             start_conv,
  output logic             start_cal,
  output logic             cal_busy,
  output logic             cal_err,
  output logic             pf_flag,
  output logic [BUS_W-1:0] reg_rd
);
  logic rsv_bits, mode_wr, data_wr, rsv_wr;

  assign rsv_bits = c_data[B_RSV0] | c_data[B_RSV1];
  assign mode_wr  = wr_commit & c_rsel & c_hbe & ~rsv_bits;
  assign rsv_wr   = wr_commit & c_rsel & (~c_hbe | rsv_bits);
  assign data_wr  = wr_commit & ~c_rsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= '0;
      start_conv <= 1'b0;
      start_cal  <= 1'b0;
      cal_busy   <= 1'b0;
      cal_err    <= 1'b0;
      pf_flag    <= 1'b0;
    end else if (pf_evt) begin
      mode       <= '{pd: 1'b1, sh: 1'b0, latched: 1'b0};
      start_conv <= 1'b0;
      start_cal  <= 1'b0;
      cal_busy   <= 1'b0;
      pf_flag    <= 1'b1;
    end else begin
      start_conv <= mode_wr | (data_wr & ~mode.sh);
      start_cal  <= mode_wr & c_data[B_CAL];
      if (mode_wr) begin
        mode.latched <= c_data[B_LATCH];
        mode.sh      <= c_data[B_SH];
        mode.pd      <= c_data[B_PD];
        if (!c_data[B_PF]) pf_flag <= 1'b0;
      end
      if (mode_wr && c_data[B_CAL]) begin
        cal_busy <= 1'b1;
        cal_err  <= 1'b0;
      end else if (cal_done) begin
        cal_busy <= 1'b0;
        if (cal_ovf) cal_err <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rd          = '0;
    reg_rd[B_LATCH] = mode.latched;
    reg_rd[B_CAL]   = cal_busy;
    reg_rd[B_SH]    = mode.sh;
    reg_rd[B_PD]    = mode.pd;
    reg_rd[B_PF]    = pf_flag;
    reg_rd[B_CERR]  = cal_err;
  end

  p_conv_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    start_conv |=> !start_conv);
  p_cal_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (start_cal && !pf_evt) |=> cal_busy);
  p_cerr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    start_cal |-> !cal_err);
  p_rsv_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (rsv_wr && !pf_evt) |=> ($stable(mode) && !start_conv && !start_cal));
  p_pf_force_r12: assert property (@(posedge clk) disable iff (rst)
    pf_evt |=> (mode.pd && !mode.sh && !mode.latched && pf_flag));
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latched,
  input  logic             result_valid,
  input  logic [RES_W-1:0] result,
  input  logic             rd_commit,
  input  logic             c_rsel,
  input  logic             c_hbe,
  input  logic             sel_hi,
  output logic [BUS_W-1:0] byte_out
);
  localparam int HI_W = RES_W - BUS_W;

  logic [RES_W-1:0] res_q;
  logic             held;
  logic             release_rd;

  assign release_rd = rd_commit & ~c_rsel & c_hbe;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      held  <= 1'b0;
    end else if (result_valid && (!latched || !held || release_rd)) begin
      res_q <= result;
      held  <= latched;
    end else if (release_rd) begin
      held <= 1'b0;
    end
  end

  always_comb begin
    if (sel_hi) byte_out = {{(BUS_W-HI_W){1'b0}}, res_q[RES_W-1:BUS_W]};
    else        byte_out = res_q[BUS_W-1:0];
  end

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (latched && held && !release_rd) |=> $stable(res_q));
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_pkg::*;
#(
  parameter int RES_W = adc_host_pkg::RES_W,
  parameter int BUS_W = adc_host_pkg::BUS_W,
  parameter int CH_W  = adc_host_pkg::CH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             hbe,
  input  logic             reg_sel,
  input  logic [CH_W-1:0]  addr,
  input  logic [BUS_W-1:0] dq_i,
  output logic [BUS_W-1:0] dq_o,
  output logic             dq_oe,
  input  logic             result_valid,
  input  logic [RES_W-1:0] result,
  input  logic             cal_done,
  input  logic             cal_ovf,
  input  logic             pwr_fail_evt,
  output logic             start_conv,
  output logic             start_cal,
  output logic             latched_mode,
  output logic             sh_mode,
  output logic             pwr_down,
  output logic [CH_W-1:0]  chan
);
  logic             wr_commit, rd_commit, c_hbe, c_rsel;
  logic [CH_W-1:0]  c_addr;
  logic [BUS_W-1:0] c_data, reg_rd, res_byte;
  logic             cal_busy, cal_err, pf_flag;
  mode_t            mode;

  adc_bus_strobe #(.BUS_W(BUS_W), .CH_W(CH_W)) u_strobe (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .hbe(hbe), .reg_sel(reg_sel), .addr(addr), .dq_i(dq_i),
    .wr_commit(wr_commit), .rd_commit(rd_commit), .c_hbe(c_hbe),
    .c_rsel(c_rsel), .c_addr(c_addr), .c_data(c_data)
  );

  adc_mode_reg #(.BUS_W(BUS_W)) u_mode (
    .clk(clk), .rst(rst), .wr_commit(wr_commit), .c_rsel(c_rsel),
    .c_hbe(c_hbe), .c_data(c_data), .cal_done(cal_done),
    .cal_ovf(cal_ovf), .pf_evt(pwr_fail_evt), .mode(mode),
    .start_conv(start_conv), .start_cal(start_cal), .cal_busy(cal_busy),
    .cal_err(cal_err), .pf_flag(pf_flag), .reg_rd(reg_rd)
  );

  adc_result_hold #(.RES_W(RES_W), .BUS_W(BUS_W)) u_res (
    .clk(clk), .rst(rst), .latched(mode.latched),
    .result_valid(result_valid), .result(result), .rd_commit(rd_commit),
    .c_rsel(c_rsel), .c_hbe(c_hbe), .sel_hi(hbe), .byte_out(res_byte)
  );

  // channel latch: every data-space write, regardless of mode
  always_ff @(posedge clk) begin
    if (rst)                        chan <= '0;
    else if (wr_commit && !c_rsel)  chan <= c_addr;
  end

  assign latched_mode = mode.latched;
  assign sh_mode      = mode.sh;
  assign pwr_down     = mode.pd;

  assign dq_oe = ~cs_n & ~rd_n;
  assign dq_o  = (reg_sel && hbe) ? reg_rd : res_byte;

  p_sh_no_start_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && !c_rsel && sh_mode && !pwr_fail_evt) |=> !start_conv);
endmodule

// File: tb/test_adc_host_if.sv
module test_adc_host_if;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hbe = 1'b0, reg_sel = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  dq_i = '0;
  logic [7:0]  dq_o;
  logic        dq_oe;
  logic        result_valid = 1'b0;
  logic [11:0] result = '0;
  logic        cal_done = 1'b0, cal_ovf = 1'b0, pwr_fail_evt = 1'b0;
  logic        start_conv, start_cal, latched_mode, sh_mode, pwr_down;
  logic [1:0]  chan;

  int vectors = 0;
  int errors  = 0;
  int conv_cnt = 0;
  int cal_cnt  = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  adc_host_if i_adc_host_if (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .hbe(hbe),
    .reg_sel(reg_sel), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
    .result_valid(result_valid), .result(result), .cal_done(cal_done),
    .cal_ovf(cal_ovf), .pwr_fail_evt(pwr_fail_evt), .start_conv(start_conv),
    .start_cal(start_cal), .latched_mode(latched_mode), .sh_mode(sh_mode),
    .pwr_down(pwr_down), .chan(chan)
  );

  always @(posedge clk) begin
    if (!rst && start_conv) conv_cnt++;
    if (!rst && start_cal)  cal_cnt++;
  end

  task automatic chk(string req, int act, int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // scoreboard monitor: compares bus bytes as they are observed
  initial begin
    forever begin
      wait (act_q.size() != 0);
      chk(tag_q.pop_front(), int'(act_q.pop_front()), int'(exp_q.pop_front()));
    end
  end

  task automatic bus_write(input logic rs, input logic hb, input logic [1:0] a,
                           input logic [7:0] d);
    @(posedge clk); #1;
    reg_sel = rs; hbe = hb; addr = a; dq_i = d; cs_n = 0; wr_n = 0;
    @(negedge clk);
    chk("R11 oe during write", int'(dq_oe), 0);
    @(posedge clk); #1;
    cs_n = 1; wr_n = 1;
    @(posedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic bus_read(input logic rs, input logic hb, input logic [7:0] expv,
                          input string req);
    @(posedge clk); #1;
    reg_sel = rs; hbe = hb; cs_n = 0; rd_n = 0;
    @(negedge clk);
    chk("R11 oe during read", int'(dq_oe), 1);
    exp_q.push_back(expv); tag_q.push_back(req); act_q.push_back(dq_o);
    @(posedge clk); #1;
    cs_n = 1; rd_n = 1;
    @(negedge clk);
    chk("R11 oe after read", int'(dq_oe), 0);
    @(posedge clk); #1;
  endtask

  task automatic pulse_in(input int which, input logic ovf, input logic [11:0] r);
    @(posedge clk); #1;
    case (which)
      0: begin result = r; result_valid = 1; end
      1: begin cal_done = 1; cal_ovf = ovf; end
      default: pwr_fail_evt = 1;
    endcase
    @(posedge clk); #1;
    result_valid = 0; cal_done = 0; cal_ovf = 0; pwr_fail_evt = 0;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    wait (act_q.size() == 0);
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual hang expected completion");
      finish_run();
    end
  end

  initial begin
    int c0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R11 oe idle after reset", int'(dq_oe), 0);
    chk("R4 reset levels", int'({latched_mode, sh_mode, pwr_down}), 0);
    chk("R9 reset chan", int'(chan), 0);
    bus_read(1, 1, 8'h00, "R1 reset register");

    // R1 R4 R6: set bits 0,2,3
    c0 = conv_cnt;
    bus_write(1, 1, 0, 8'h0D);
    chk("R6 one start per mode write", conv_cnt - c0, 1);
    chk("R4 levels after write", int'({latched_mode, sh_mode, pwr_down}), 3'b111);
    bus_read(1, 1, 8'h0D, "R1 readback 0D");

    // R8 reserved writes
    c0 = conv_cnt;
    bus_write(1, 1, 0, 8'h10);
    bus_write(1, 1, 0, 8'h40);
    bus_write(1, 0, 0, 8'h00);
    chk("R8 no start on reserved", conv_cnt - c0, 0);
    bus_read(1, 1, 8'h0D, "R8 register unchanged");

    // R3 R7 calibration
    c0 = cal_cnt;
    bus_write(1, 1, 0, 8'h02);
    chk("R3 one start_cal", cal_cnt - c0, 1);
    bus_read(1, 1, 8'h02, "R3 busy bit set");
    pulse_in(1, 1, '0);
    bus_read(1, 1, 8'h80, "R7 overflow sets error");
    bus_write(1, 1, 0, 8'h02);
    bus_read(1, 1, 8'h02, "R7 start clears error");
    pulse_in(1, 0, '0);
    bus_read(1, 1, 8'h00, "R7 clean cal stays clear");

    // R12 R5 power fail
    bus_write(1, 1, 0, 8'h05);
    pulse_in(2, 0, '0);
    chk("R12 forced levels", int'({latched_mode, sh_mode, pwr_down}), 3'b001);
    bus_read(1, 1, 8'h28, "R12 power-fail state");
    bus_write(1, 1, 0, 8'h20);
    bus_read(1, 1, 8'h20, "R5 bit5 high keeps flag");
    bus_write(1, 1, 0, 8'h00);
    bus_read(1, 1, 8'h00, "R5 bit5 low clears flag");

    // R9 channel latch
    c0 = conv_cnt;
    bus_write(0, 0, 2'd2, 8'h00);
    chk("R9 chan latched", int'(chan), 2);
    chk("R9 start outside sh", conv_cnt - c0, 1);
    bus_write(1, 1, 0, 8'h04);
    c0 = conv_cnt;
    bus_write(0, 0, 2'd3, 8'h00);
    chk("R9 chan latched in sh", int'(chan), 3);
    chk("R9 no start in sh", conv_cnt - c0, 0);
    bus_write(1, 1, 0, 8'h00);

    // R10 R2 transparent results
    pulse_in(0, 0, 12'hABC);
    bus_read(0, 0, 8'hBC, "R10 low byte");
    bus_read(0, 1, 8'h0A, "R10 high nibble");
    pulse_in(0, 0, 12'h123);
    bus_read(0, 0, 8'h23, "R2 transparent update");

    // R2 latched results
    bus_write(1, 1, 0, 8'h01);
    pulse_in(0, 0, 12'h456);
    pulse_in(0, 0, 12'h789);
    bus_read(0, 0, 8'h56, "R2 held low byte");
    bus_read(0, 1, 8'h04, "R2 held high byte");
    pulse_in(0, 0, 12'h321);
    bus_read(0, 0, 8'h21, "R2 release after high read");

    done = 1'b1;
    finish_run();
  end
endmodule